// File: doc/BRIEF.md
# Seven-Channel Selectable Clock Divider Bank

This block divides one source clock down to seven independent output channels. Each channel has its own 2-bit select field. The field either disables the channel, leaving its outputs floating, or picks a division ratio of 2, 4 or 8. Every enabled channel drives a true level and its complement as a differential pair, and the pair holds a 50% duty cycle.

All channels take their levels from one shared 3-bit phase counter. The rising edges of every enabled channel therefore line up at phase zero. The block runs on a single fabric clock, and each source is modelled as a clock-enable tick. `synth_tick` stands for an edge of the synthesized clock and `ref_tick` for an edge of the reference. The `bypass_sel` input picks which of the two ticks advances the counter.

Each channel is a small state machine with four states: `CH_OFF`, `CH_DIV2`, `CH_DIV4` and `CH_DIV8`. There is one transition rule, `LOAD_AT_WRAP`: when the counter rolls from 7 to 0, the state takes the value of the channel's select field. While `master_rst` is high the state follows the field directly, the counter is held at zero and the outputs are forced to a defined differential level.

Top module: `clkdiv_bank`

## Requirements
- R1: There are seven channels, and channel k is steered only by bits `sel[2k+1:2k]`.
- R2: In state `CH_OFF` (select code 2'b00) the channel drives `q_oe[k]` low and leaves `q_true[k]` and `q_comp[k]` at high impedance.
- R3: Select code 2'b01 divides by 2, code 2'b11 divides by 4 and code 2'b10 divides by 8, counted in selected source ticks. `q_true[k]` is high for the first half of each period, where a period starts at phase 0 of the shared counter.
- R4: For every enabled channel, `q_comp[k]` is always the inverse of `q_true[k]`.
- R5: While `master_rst` is high, every `q_true` is 0, every `q_comp` is 1 and every `q_oe` is 1, in the same cycle. The counter is held at phase 0, and each channel's state takes its select field at every clock.
- R6: With `bypass_sel` at 1, only `ref_tick` advances the counter; with it at 0, only `synth_tick` does. A tick from the unselected source changes no output.
- R7: A new select code takes effect only on the tick that wraps the counter from 7 to 0. A change made at any other phase leaves the outputs on the old ratio.
- R8: The rising edges of all enabled channels fall together at phase 0, so the divide-by-2, -4 and -8 outputs stay phase-aligned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock on which all state updates |
| master_rst | input | 1 | Active-high reset of counter and channels |
| bypass_sel | input | 1 | 1: count reference ticks, 0: count synthesized ticks |
| synth_tick | input | 1 | One edge of the synthesized source |
| ref_tick | input | 1 | One edge of the reference source |
| sel | input | 14 | Two select bits per channel |
| q_true | output | 7 | True output of each channel |
| q_comp | output | 7 | Complement output of each channel |
| q_oe | output | 7 | Output enable of each channel |

## Verification
The effect of reset is combinational, so outputs change in the same cycle that `master_rst` changes. A selected tick moves the outputs one clock edge later, since the only register on the path is the counter or the channel state. The bench drives inputs just after a falling edge and samples the outputs at the following falling edge. Its model is updated with the inputs that were present at the rising edge in between, so every comparison falls in the cycle where the result is due.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        CH_OFF  = 2'b00,
        CH_DIV2 = 2'b01,
        CH_DIV8 = 2'b10,
        CH_DIV4 = 2'b11
    } ch_state_t;
endpackage

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
#(
    parameter int W = PHASE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] phase,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)
            phase <= '0;
        else if (adv)
            phase <= phase + 1'b1;
    end

    assign wrap = adv && (phase == LAST);
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap,
    input  logic [1:0]         code,
    input  logic [PHASE_W-1:0] phase,
    output logic               out_true,
    output logic               out_comp,
    output logic               out_oe
);
    ch_state_t state;
    logic      lvl;
    logic      oe;

    // state register: LOAD_AT_WRAP, or follow the field while in reset
    always_ff @(posedge clk) begin
        if (rst || wrap)
            state <= ch_state_t'(code);
    end

    // output decode
    always_comb begin
        lvl = 1'b0;
        oe  = 1'b1;
        unique case (state)
            CH_OFF:  oe  = 1'b0;
            CH_DIV2: lvl = ~phase[0];
            CH_DIV4: lvl = ~phase[1];
            CH_DIV8: lvl = ~phase[2];
        endcase
        if (rst) begin
            lvl = 1'b0;
            oe  = 1'b1;
        end
    end

    assign out_oe   = oe;
    assign out_true = oe ? lvl  : 1'bz;
    assign out_comp = oe ? ~lvl : 1'bz;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int NCH = 7
) (
    input  logic             clk,
    input  logic             master_rst,
    input  logic             bypass_sel,
    input  logic             synth_tick,
    input  logic             ref_tick,
    input  logic [2*NCH-1:0] sel,
    output logic [NCH-1:0]   q_true,
    output logic [NCH-1:0]   q_comp,
    output logic [NCH-1:0]   q_oe
);
    localparam int SELW = 2 * NCH;

    logic               adv;
    logic               wrap;
    logic [PHASE_W-1:0] phase;

    assign adv = bypass_sel ? ref_tick : synth_tick;

    clkdiv_phase #(.W(PHASE_W)) u_phase (
        .clk   (clk),
        .rst   (master_rst),
        .adv   (adv),
        .phase (phase),
        .wrap  (wrap)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        clkdiv_chan u_chan (
            .clk      (clk),
            .rst      (master_rst),
            .wrap     (wrap),
            .code     (sel[2*k +: 2]),
            .phase    (phase),
            .out_true (q_true[k]),
            .out_comp (q_comp[k]),
            .out_oe   (q_oe[k])
        );
    end

    if (SELW != 2 * NCH) begin : g_bad_width
        initial $error("select width mismatch");
    end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NCH = 7
) (
    input logic           clk,
    input logic           master_rst,
    input logic           bypass_sel,
    input logic           synth_tick,
    input logic           ref_tick,
    input logic [NCH-1:0] q_true,
    input logic [NCH-1:0] q_comp,
    input logic [NCH-1:0] q_oe
);
    logic src_tick;
    assign src_tick = bypass_sel ? ref_tick : synth_tick;

    AST_RESET_LEVELS: assert property (@(posedge clk)
        master_rst |-> (q_true == '0) && (q_comp == '1)); // R5

    AST_RESET_ENABLES: assert property (@(posedge clk)
        master_rst |-> (q_oe == '1)); // R5

    AST_PAIR_INVERSE: assert property (@(posedge clk) disable iff (master_rst)
        (q_comp & q_oe) == (~q_true & q_oe)); // R4

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (master_rst)
        !src_tick |=> $stable(q_oe) && $stable(q_true & q_oe)); // R6
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .master_rst (master_rst),
    .bypass_sel (bypass_sel),
    .synth_tick (synth_tick),
    .ref_tick   (ref_tick),
    .q_true     (q_true),
    .q_comp     (q_comp),
    .q_oe       (q_oe)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;
    localparam int NCH = 7;

    logic             clk = 1'b0;
    logic             master_rst = 1'b1;
    logic             bypass_sel = 1'b0;
    logic             synth_tick = 1'b0;
    logic             ref_tick = 1'b0;
    logic [2*NCH-1:0] sel = '0;
    logic [NCH-1:0]   q_true;
    logic [NCH-1:0]   q_comp;
    logic [NCH-1:0]   q_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int       m_phase;
    bit [1:0] m_mode [NCH];

    always #5 clk = ~clk;

    clkdiv_bank #(.NCH(NCH)) uut (
        .clk(clk), .master_rst(master_rst), .bypass_sel(bypass_sel),
        .synth_tick(synth_tick), .ref_tick(ref_tick), .sel(sel),
        .q_true(q_true), .q_comp(q_comp), .q_oe(q_oe)
    );

    // period from code: 01 -> 2, 11 -> 4, 10 -> 8 (R3)
    function automatic int period_of(bit [1:0] code);
        case (code)
            2'b01:   return 2;
            2'b11:   return 4;
            2'b10:   return 8;
            default: return 0;
        endcase
    endfunction

    function automatic bit level_of(bit [1:0] code, int ph);
        int p = period_of(code);
        return (ph % p) < (p / 2);
    endfunction

    task automatic fail(string tag, int k, string what, logic act, logic exp);
        errors++;
        $display("FAIL %s ch%0d %s: actual %b expected %b", tag, k, what, act, exp);
    endtask

    task automatic check_all(string tag);
        for (int k = 0; k < NCH; k++) begin
            logic e_oe, e_t;
            if (master_rst) begin
                e_oe = 1'b1; e_t = 1'b0;
            end else if (m_mode[k] == 2'b00) begin
                e_oe = 1'b0; e_t = 1'b0;
            end else begin
                e_oe = 1'b1; e_t = level_of(m_mode[k], m_phase);
            end
            checks++;
            if (q_oe[k] !== e_oe) fail(tag, k, "oe", q_oe[k], e_oe);
            if (e_oe) begin
                checks++;
                if (q_true[k] !== e_t) fail(tag, k, "true", q_true[k], e_t);
                checks++;
                if (q_comp[k] !== ~e_t) fail("R4", k, "comp", q_comp[k], ~e_t);
            end
        end
    endtask

    // drive one cycle, advance the model as the next rising edge will, then check
    task automatic step(bit rst, bit byp, bit st, bit rt, logic [2*NCH-1:0] s, string tag);
        master_rst = rst; bypass_sel = byp; synth_tick = st; ref_tick = rt; sel = s;
        if (rst) begin
            m_phase = 0;
            for (int k = 0; k < NCH; k++) m_mode[k] = s[2*k +: 2];
        end else if (byp ? rt : st) begin
            if (m_phase == 7)
                for (int k = 0; k < NCH; k++) m_mode[k] = s[2*k +: 2];
            m_phase = (m_phase + 1) % 8;
        end
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [2*NCH-1:0] mix;
        logic [2*NCH-1:0] cur;
        int unsigned r;
        mix = 14'b11_10_01_00_11_10_01;
        r = $urandom(32'h5eed_c10c);
        m_phase = 0;
        for (int k = 0; k < NCH; k++) m_mode[k] = 2'b00;
        @(negedge clk);

        // R5: reset state, even with ticks and an off channel
        for (int i = 0; i < 3; i++) step(1, 0, 1, 1, mix, "R5");

        // R1 R3 R8: each channel on its own field, all three ratios aligned
        for (int i = 0; i < 24; i++) step(0, 0, 1, 0, mix, "R1 R3 R8");

        // R2: all channels off, taking effect at wrap
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, '0, "R2");

        // R6: bypass selected, synthesized ticks ignored
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, mix, "R6");
        for (int i = 0; i < 6; i++)  step(0, 1, 1, 0, mix, "R6");
        for (int i = 0; i < 12; i++) step(0, 1, i[0], 1, mix, "R6");
        for (int i = 0; i < 6; i++)  step(0, 0, 0, 1, mix, "R6");

        // R7: code change in mid-period waits for the wrap
        for (int i = 0; i < 3; i++)  step(0, 0, 1, 0, mix, "R7");
        for (int i = 0; i < 12; i++) step(0, 0, 1, 0, ~mix, "R7");

        // R5: reset in mid-run forces levels at once
        step(0, 0, 1, 0, mix, "R5");
        for (int i = 0; i < 2; i++) step(1, 0, 1, 0, mix, "R5");

        // constrained random mix
        cur = mix;
        for (int i = 0; i < 4000; i++) begin
            bit rst, byp, st, rt;
            rst = ($urandom % 100) < 2;
            byp = ($urandom % 100) < 25;
            st  = ($urandom % 100) < 70;
            rt  = ($urandom % 100) < 50;
            if (($urandom % 100) < 5) cur = 14'($urandom);
            step(rst, byp, st, rt, cur, "R3");
        end

        finish_run();
    end
endmodule